// File: doc/BRIEF.md
# Cache Line Dictionary Compressor

This block packs a 32-byte cache line into a short run of 12-bit codes. It uses a string dictionary that is shared by every line and that keeps growing from line to line. Codes 0 to 255 stand for single byte values and take no storage. Every higher code is one RAM entry. An entry holds a parent code and one appended byte, and the string it stands for is the parent's string followed by that byte. The compressor reads one byte per cycle. It keeps extending the current match while the pair (current code, next byte) is found in the dictionary. When the pair is missing, it emits the current code and tries to store that pair as a new entry.

Lookup reads a single hash slot per byte, so a lookup finishes in one cycle. New codes are handed out by an allocation cursor that moves round-robin over the stored code range. A cleanup port lets a separate reference-marking process release entries. Every code that is emitted or created is shown on a pair of strobes, so the marking logic can see which entries are still referenced. When a line finishes, the block reports the code count, the code buffer, the packed size in bytes and a flag telling whether the line is worth storing in compressed form.

Top module: `lzw_line_compressor`

## Requirements
- R1: `in_ready_o` is high only while idle. A line is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high, and `in_valid_i` has no effect at any other time. `done_o` is high for exactly the 33rd cycle after the accepting edge, and `in_ready_o` returns in the cycle that follows.
- R2: Byte k of the line sits at `in_line_i[8k+7:8k]`, and byte 0 is consumed first. Codes 0 to 255 mean the byte of the same value.
- R3: In cycle k after acceptance (k = 1..31), byte k is looked up together with the current code. On a match, the current code becomes the matched entry and nothing is emitted. On a miss, the current code is shown on `touch_emit_code_o` and appended to the code buffer, and byte k becomes the current code.
- R4: Every miss in R3 is an allocation attempt for the entry (current code, byte k). If the cursor's code is free, that code is filled and shown on `touch_new_code_o` in the same cycle. The cursor moves forward on every attempt and wraps from 4095 back to 256. The cursor starts at 256 after reset.
- R5: The lookup key is the 20-bit value {current code, byte}. Its slot index is key[9:0] XOR key[19:10]. A new entry takes over its slot. A lookup matches only if the slot's code is in use and stores exactly that pair.
- R6: If the cursor's code is already in use, no entry is made and no `touch_new` strobe appears. Compression carries on using the entries that already exist.
- R7: A pulse on `free_valid_i` with `free_code_i` ≥ 256 marks that entry free. The entry then stops matching and is reused when the cursor reaches it. If a code is freed and allocated in the same cycle, the allocation wins.
- R8: The dictionary is kept from one line to the next and is emptied only by reset.
- R9: In cycle 32 the last current code is emitted and no entry is made.
- R10: While `done_o` is high, `code_count_o` holds the number of codes. Code j is at `codes_o[12j+11:12j]`. `comp_bytes_o` equals ceil(count×12/8), and `compressible_o` is high exactly when `comp_bytes_o` < 16.
- R11: After reset, `in_ready_o` is 1, `done_o` and both touch strobes are 0, and the dictionary is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A line is offered |
| in_ready_o | output | 1 | Idle; a line can be accepted |
| in_line_i | input | 256 | Line data, byte 0 in the low bits |
| free_valid_i | input | 1 | Cleanup release strobe |
| free_code_i | input | 12 | Code to release |
| touch_emit_valid_o | output | 1 | A code is emitted this cycle |
| touch_emit_code_o | output | 12 | The emitted code |
| touch_new_valid_o | output | 1 | An entry is created this cycle |
| touch_new_code_o | output | 12 | The created code |
| done_o | output | 1 | Result is valid (one cycle) |
| code_count_o | output | 6 | Number of codes |
| comp_bytes_o | output | 6 | Packed size in bytes |
| compressible_o | output | 1 | Packed size is under the threshold |
| codes_o | output | 384 | Code buffer, code j at bits 12j+11:12j |

## Verification
The bench keeps its own dictionary, hash slots and cursor, and checks both touch strobes on every cycle of every line. A design with the wrong slot fold, or one that skips checking the pair stored at the slot, emits a different code stream as soon as random lines start to collide. The bench fills the dictionary completely and then checks that no entry is created. A design that keeps allocating would overwrite entries that are still live. It then frees the two codes just ahead of the cursor and checks that exactly those two are handed out next, which catches a cursor that skips or fails to wrap. Repeated lines show that the dictionary carries over between lines. An offer that arrives while the block is busy shows that a line is accepted only through the handshake. The flush cycle shows that the final code is emitted but never stored.

// File: rtl/lzw_pkg.sv
package lzw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_DONE
  } cmp_state_e;
endpackage

// File: rtl/lzw_dict.sv
module lzw_dict #(
  parameter int SYM_W  = 8,
  parameter int CODE_W = 12,
  parameter int HASH_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] lk_ptr_i,
  input  logic [SYM_W-1:0]  lk_sym_i,
  output logic              lk_hit_o,
  output logic [CODE_W-1:0] lk_code_o,
  input  logic              add_i,
  output logic              alloc_ok_o,
  output logic [CODE_W-1:0] alloc_code_o,
  input  logic              free_valid_i,
  input  logic [CODE_W-1:0] free_code_i
);
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int BASE      = 1 << SYM_W;
  localparam int NENT      = NUM_CODES - BASE;
  localparam int ENT_AW    = $clog2(NENT);
  localparam int HDEPTH    = 1 << HASH_W;
  localparam int KEY_W     = CODE_W + SYM_W;
  localparam int NCHUNK    = (KEY_W + HASH_W - 1) / HASH_W;
  localparam int PAD_W     = NCHUNK * HASH_W;

  logic [CODE_W-1:0] ptr_q   [NENT];
  logic [SYM_W-1:0]  sym_q   [NENT];
  logic [CODE_W-1:0] hcode_q [HDEPTH];
  logic [NENT-1:0]   used_q;
  logic [HDEPTH-1:0] hval_q;
  logic [CODE_W-1:0] cursor_q;

  function automatic logic [ENT_AW-1:0] ent_of(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] d;
    d = c - CODE_W'(BASE);
    return d[ENT_AW-1:0];
  endfunction

  // slot index: xor-fold of {ptr, sym}
  logic [PAD_W-1:0]  key_pad;
  logic [HASH_W-1:0] hidx;
  assign key_pad = PAD_W'({lk_ptr_i, lk_sym_i});
  always_comb begin
    hidx = '0;
    for (int k = 0; k < NCHUNK; k++) hidx ^= key_pad[k*HASH_W +: HASH_W];
  end

  logic [CODE_W-1:0] cand;
  logic [ENT_AW-1:0] cand_e, cur_e, free_e;
  assign cand   = hcode_q[hidx];
  assign cand_e = ent_of(cand);
  assign cur_e  = ent_of(cursor_q);
  assign free_e = ent_of(free_code_i);

  assign lk_hit_o  = hval_q[hidx] && used_q[cand_e] &&
                     (ptr_q[cand_e] == lk_ptr_i) && (sym_q[cand_e] == lk_sym_i);
  assign lk_code_o = cand;

  assign alloc_ok_o   = !used_q[cur_e];
  assign alloc_code_o = cursor_q;

  logic [CODE_W-1:0] cursor_nxt;
  assign cursor_nxt = (cursor_q == CODE_W'(NUM_CODES - 1)) ? CODE_W'(BASE)
                                                           : cursor_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q   <= '0;
      hval_q   <= '0;
      cursor_q <= CODE_W'(BASE);
    end else begin
      if (free_valid_i && (free_code_i >= CODE_W'(BASE))) used_q[free_e] <= 1'b0;
      if (add_i) begin
        cursor_q <= cursor_nxt;
        if (alloc_ok_o) begin
          used_q[cur_e] <= 1'b1;   // alloc wins over same-cycle free
          hval_q[hidx]  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (add_i && alloc_ok_o) begin
      ptr_q[cur_e]  <= lk_ptr_i;
      sym_q[cur_e]  <= lk_sym_i;
      hcode_q[hidx] <= cursor_q;
    end
  end

  assert_hit_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_code_o >= CODE_W'(BASE)));

  assert_alloc_marks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && alloc_ok_o) |=> used_q[$past(cur_e)]);

  assert_cursor_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |=> (cursor_q != $past(cursor_q)));
endmodule

// File: rtl/lzw_ctrl.sv
module lzw_ctrl
  import lzw_pkg::*;
#(
  parameter int SYM_W      = 8,
  parameter int CODE_W     = 12,
  parameter int LINE_BYTES = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  input  logic [LINE_BYTES*SYM_W-1:0] in_line_i,
  output logic                        in_ready_o,
  output logic [CODE_W-1:0]           lk_ptr_o,
  output logic [SYM_W-1:0]            lk_sym_o,
  input  logic                        lk_hit_i,
  input  logic [CODE_W-1:0]           lk_code_i,
  output logic                        add_o,
  input  logic                        alloc_ok_i,
  input  logic [CODE_W-1:0]           alloc_code_i,
  output logic                        emit_valid_o,
  output logic [CODE_W-1:0]           emit_code_o,
  output logic                        new_valid_o,
  output logic [CODE_W-1:0]           new_code_o,
  output logic                        start_o,
  output logic                        done_o
);
  localparam int LINE_W = LINE_BYTES * SYM_W;
  localparam int IDX_W  = $clog2(LINE_BYTES);
  localparam int BASE   = 1 << SYM_W;

  cmp_state_e        state_q;
  logic [LINE_W-1:0] line_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CODE_W-1:0] cur_q;
  logic [SYM_W-1:0]  sym;
  logic              run, miss;

  assign sym  = line_q[int'(idx_q)*SYM_W +: SYM_W];
  assign run  = (state_q == ST_RUN);
  assign miss = run && !lk_hit_i;

  assign in_ready_o   = (state_q == ST_IDLE);
  assign start_o      = in_valid_i && in_ready_o;
  assign done_o       = (state_q == ST_DONE);
  assign lk_ptr_o     = cur_q;
  assign lk_sym_o     = sym;
  assign add_o        = miss;
  assign new_valid_o  = miss && alloc_ok_i;
  assign new_code_o   = alloc_code_i;
  assign emit_valid_o = miss || (state_q == ST_FLUSH);
  assign emit_code_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      idx_q   <= '0;
      cur_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_o) begin
          line_q  <= in_line_i;
          cur_q   <= CODE_W'(in_line_i[SYM_W-1:0]);
          idx_q   <= IDX_W'(1);
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          cur_q <= lk_hit_i ? lk_code_i : CODE_W'(sym);
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(LINE_BYTES - 1)) state_q <= ST_FLUSH;
        end
        ST_FLUSH: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !in_ready_o);

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && in_ready_o));

  assert_extend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && lk_hit_i) |=> (cur_q >= CODE_W'(BASE)));
endmodule

// File: rtl/lzw_outbuf.sv
module lzw_outbuf #(
  parameter int SYM_W        = 8,
  parameter int CODE_W       = 12,
  parameter int LINE_BYTES   = 32,
  parameter int THRESH_BYTES = 16
) (
  input  logic                                               clk_i,
  input  logic                                               rst_ni,
  input  logic                                               clear_i,
  input  logic                                               push_i,
  input  logic [CODE_W-1:0]                                  push_code_i,
  output logic [$clog2(LINE_BYTES+1)-1:0]                    count_o,
  output logic [$clog2((LINE_BYTES*CODE_W+SYM_W-1)/SYM_W+1)-1:0] bytes_o,
  output logic                                               compressible_o,
  output logic [LINE_BYTES*CODE_W-1:0]                       codes_o
);
  localparam int CNT_W   = $clog2(LINE_BYTES + 1);
  localparam int BUF_AW  = $clog2(LINE_BYTES);
  localparam int BYTES_W = $clog2((LINE_BYTES*CODE_W + SYM_W - 1) / SYM_W + 1);
  localparam int BITS_W  = $clog2(LINE_BYTES*CODE_W + SYM_W);

  logic [CODE_W-1:0] buf_q [LINE_BYTES];
  logic [CNT_W-1:0]  count_q;
  logic [BITS_W-1:0] bits_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      for (int j = 0; j < LINE_BYTES; j++) buf_q[j] <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (push_i) begin
      buf_q[count_q[BUF_AW-1:0]] <= push_code_i;
      count_q <= count_q + 1'b1;
    end
  end

  assign bits_w         = BITS_W'(count_q) * BITS_W'(CODE_W);
  assign bytes_o        = BYTES_W'((bits_w + BITS_W'(SYM_W - 1)) / BITS_W'(SYM_W));
  assign compressible_o = (bytes_o < BYTES_W'(THRESH_BYTES));
  assign count_o        = count_q;

  for (genvar j = 0; j < LINE_BYTES; j++) begin : g_flat
    assign codes_o[j*CODE_W +: CODE_W] = buf_q[j];
  end

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_q < CNT_W'(LINE_BYTES)));

  assert_clear_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !push_i) |=> (count_q == '0));
endmodule

// File: rtl/lzw_line_compressor.sv
module lzw_line_compressor #(
  parameter int SYM_W        = 8,
  parameter int CODE_W       = 12,
  parameter int HASH_W       = 10,
  parameter int LINE_BYTES   = 32,
  parameter int THRESH_BYTES = 16
) (
  input  logic                                                   clk_i,
  input  logic                                                   rst_ni,
  input  logic                                                   in_valid_i,
  output logic                                                   in_ready_o,
  input  logic [LINE_BYTES*SYM_W-1:0]                            in_line_i,
  input  logic                                                   free_valid_i,
  input  logic [CODE_W-1:0]                                      free_code_i,
  output logic                                                   touch_emit_valid_o,
  output logic [CODE_W-1:0]                                      touch_emit_code_o,
  output logic                                                   touch_new_valid_o,
  output logic [CODE_W-1:0]                                      touch_new_code_o,
  output logic                                                   done_o,
  output logic [$clog2(LINE_BYTES+1)-1:0]                        code_count_o,
  output logic [$clog2((LINE_BYTES*CODE_W+SYM_W-1)/SYM_W+1)-1:0] comp_bytes_o,
  output logic                                                   compressible_o,
  output logic [LINE_BYTES*CODE_W-1:0]                           codes_o
);
  logic [CODE_W-1:0] lk_ptr, lk_code, alloc_code;
  logic [SYM_W-1:0]  lk_sym;
  logic              lk_hit, add, alloc_ok, start;

  lzw_ctrl #(.SYM_W(SYM_W), .CODE_W(CODE_W), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_line_i    (in_line_i),
    .in_ready_o   (in_ready_o),
    .lk_ptr_o     (lk_ptr),
    .lk_sym_o     (lk_sym),
    .lk_hit_i     (lk_hit),
    .lk_code_i    (lk_code),
    .add_o        (add),
    .alloc_ok_i   (alloc_ok),
    .alloc_code_i (alloc_code),
    .emit_valid_o (touch_emit_valid_o),
    .emit_code_o  (touch_emit_code_o),
    .new_valid_o  (touch_new_valid_o),
    .new_code_o   (touch_new_code_o),
    .start_o      (start),
    .done_o       (done_o)
  );

  lzw_dict #(.SYM_W(SYM_W), .CODE_W(CODE_W), .HASH_W(HASH_W)) u_dict (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_ptr_i     (lk_ptr),
    .lk_sym_i     (lk_sym),
    .lk_hit_o     (lk_hit),
    .lk_code_o    (lk_code),
    .add_i        (add),
    .alloc_ok_o   (alloc_ok),
    .alloc_code_o (alloc_code),
    .free_valid_i (free_valid_i),
    .free_code_i  (free_code_i)
  );

  lzw_outbuf #(.SYM_W(SYM_W), .CODE_W(CODE_W), .LINE_BYTES(LINE_BYTES),
               .THRESH_BYTES(THRESH_BYTES)) u_outbuf (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (start),
    .push_i         (touch_emit_valid_o),
    .push_code_i    (touch_emit_code_o),
    .count_o        (code_count_o),
    .bytes_o        (comp_bytes_o),
    .compressible_o (compressible_o),
    .codes_o        (codes_o)
  );

  assert_new_has_emit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_new_valid_o |-> (touch_emit_valid_o && touch_new_code_o >= CODE_W'(1 << SYM_W)));
endmodule

// File: tb/lzw_line_compressor_bench.sv
`timescale 1ns/1ps
module lzw_line_compressor_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_line = '0;
  logic         free_valid = 1'b0;
  logic [11:0]  free_code = '0;
  logic         emit_v, new_v, done;
  logic [11:0]  emit_c, new_c;
  logic [5:0]   cnt, nbytes;
  logic         compr;
  logic [383:0] codes;

  always #4 clk = ~clk;

  lzw_line_compressor u_lzw_line_compressor (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_line_i(in_line), .free_valid_i(free_valid), .free_code_i(free_code),
    .touch_emit_valid_o(emit_v), .touch_emit_code_o(emit_c),
    .touch_new_valid_o(new_v), .touch_new_code_o(new_c), .done_o(done),
    .code_count_o(cnt), .comp_bytes_o(nbytes), .compressible_o(compr), .codes_o(codes));

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural dictionary model
  int m_ptr[4096], m_sym[4096], m_hc[1024];
  bit m_used[4096], m_hv[1024];
  int m_cursor, m_nused;
  int e_emit[$], e_new[$], e_codes[$], a_new[$];
  int last_cnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int hsh(input int p, input int s);
    int k = (p << 8) | s;
    return (k & 1023) ^ ((k >> 10) & 1023);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) m_used[i] = 0;
    for (int i = 0; i < 1024; i++) m_hv[i] = 0;
    m_cursor = 256; m_nused = 0;
  endtask

  task automatic model_line(input logic [255:0] ln);
    int cur, s, h, c;
    bit hit;
    e_emit.delete(); e_new.delete(); e_codes.delete();
    cur = int'(ln[7:0]);
    for (int i = 1; i < 32; i++) begin
      s = int'(ln[i*8 +: 8]);
      h = hsh(cur, s);
      c = m_hc[h];
      hit = m_hv[h] && m_used[c] && m_ptr[c] == cur && m_sym[c] == s;
      if (hit) begin
        e_emit.push_back(-1); e_new.push_back(-1); cur = c;
      end else begin
        e_emit.push_back(cur); e_codes.push_back(cur);
        if (!m_used[m_cursor]) begin
          e_new.push_back(m_cursor);
          m_used[m_cursor] = 1; m_nused++;
          m_ptr[m_cursor] = cur; m_sym[m_cursor] = s;
          m_hc[h] = m_cursor; m_hv[h] = 1;
        end else e_new.push_back(-1);
        m_cursor = (m_cursor == 4095) ? 256 : m_cursor + 1;
        cur = s;
      end
    end
    e_emit.push_back(cur); e_new.push_back(-1); e_codes.push_back(cur);
  endtask

  task automatic run_line(input logic [255:0] ln, input bit junk);
    int n, eb;
    model_line(ln);
    a_new.delete();
    chk(in_ready === 1'b1, "R1 ready idle", int'(in_ready), 1);
    in_valid = 1'b1; in_line = ln;
    @(negedge clk);
    in_valid = junk; in_line = ~ln;
    for (int c = 1; c <= 32; c++) begin
      chk(in_ready === 1'b0, "R1 busy", int'(in_ready), 0);
      if (e_emit[c-1] < 0) chk(emit_v === 1'b0, "R3 no emit", int'(emit_v), 0);
      else if (c == 32) chk(emit_v === 1'b1 && int'(emit_c) == e_emit[c-1], "R9 flush emit",
                            int'(emit_c), e_emit[c-1]);
      else chk(emit_v === 1'b1 && int'(emit_c) == e_emit[c-1], "R3,R5 emit",
               int'(emit_c), e_emit[c-1]);
      if (e_new[c-1] < 0) chk(new_v === 1'b0, "R4,R6 no new", int'(new_v), 0);
      else chk(new_v === 1'b1 && int'(new_c) == e_new[c-1], "R4 new",
               int'(new_c), e_new[c-1]);
      if (new_v === 1'b1) a_new.push_back(int'(new_c));
      if (c == 32) in_valid = 1'b0;
      @(negedge clk);
    end
    n = e_codes.size();
    eb = (n * 12 + 7) / 8;
    chk(done === 1'b1, "R1 done", int'(done), 1);
    chk(int'(cnt) == n, "R10 count", int'(cnt), n);
    chk(int'(nbytes) == eb, "R10 bytes", int'(nbytes), eb);
    chk(compr === (eb < 16), "R10 compressible", int'(compr), int'(eb < 16));
    for (int j = 0; j < n; j++)
      chk(int'(codes[j*12 +: 12]) == e_codes[j], "R2,R10 code", int'(codes[j*12 +: 12]), e_codes[j]);
    last_cnt = n;
    @(negedge clk);
    chk(done === 1'b0 && in_ready === 1'b1, "R1 after done", int'(done), 0);
  endtask

  task automatic do_free(input int code);
    free_valid = 1'b1; free_code = 12'(code);
    @(negedge clk);
    free_valid = 1'b0;
    if (code >= 256 && m_used[code]) begin m_used[code] = 0; m_nused--; end
  endtask

  function automatic logic [255:0] rnd_line();
    logic [255:0] l;
    for (int i = 0; i < 32; i++) l[i*8 +: 8] = 8'($urandom);
    return l;
  endfunction

  initial begin
    logic [255:0] ln;
    int c_first, f0, f1, nnew;
    void'($urandom(7));
    model_reset();
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R11 ready", int'(in_ready), 1);
    chk(done === 1'b0 && emit_v === 1'b0 && new_v === 1'b0, "R11 quiet", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // all-zero line, then again: dictionary carries over
    run_line('0, 0);
    c_first = last_cnt;
    chk(compr === 1'b1, "R10 zero line compressible", int'(compr), 1);
    run_line('0, 0);
    chk(last_cnt < c_first, "R8 reuse", last_cnt, c_first);

    // incrementing bytes, busy offer ignored
    for (int i = 0; i < 32; i++) ln[i*8 +: 8] = 8'(i + 1);
    run_line(ln, 1);
    chk(compr === 1'b0, "R10 incompressible", int'(compr), 0);
    // two-byte pattern
    for (int i = 0; i < 32; i++) ln[i*8 +: 8] = (i % 2) ? 8'h5a : 8'ha5;
    run_line(ln, 0);
    run_line(ln, 1);

    // free codes below 256 are ignored
    do_free(3);
    run_line('0, 0);

    // fill the dictionary with random lines
    for (int k = 0; k < 400 && m_nused < 3840; k++) run_line(rnd_line(), 0);
    chk(m_nused == 3840, "R6 filled", m_nused, 3840);
    nnew = 0;
    run_line(rnd_line(), 0);
    chk(a_new.size() == 0, "R6 full no alloc", a_new.size(), 0);

    // release the two codes ahead of the cursor
    f0 = m_cursor; f1 = (m_cursor == 4095) ? 256 : m_cursor + 1;
    do_free(f0);
    do_free(f1);
    run_line(rnd_line(), 0);
    chk(a_new.size() == 2, "R7 reuse count", a_new.size(), 2);
    if (a_new.size() == 2) begin
      chk(a_new[0] == f0, "R7 first reuse", a_new[0], f0);
      chk(a_new[1] == f1, "R7 second reuse", a_new[1], f1);
    end
    for (int k = 0; k < 4; k++) run_line(rnd_line(), 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule